// File: doc/BRIEF.md
# Temporal Dual-Read Stability Checker

This block confirms that a word held in memory is steady before it is trusted. It is given an address and a cycle budget. It then reads that location over a single-outstanding valid/ready read port until two successive responses carry identical data. When a pair disagrees, the block does not accept the value. It reads again, and the later read of the failed pair becomes the reference for the next comparison. Each retry therefore costs exactly one more read.

The budget is a 16-bit unsigned count of cycles. It starts at the cycle the request is accepted and counts every busy cycle, including cycles stalled on the read port. When the budget runs out, the request ends with a timeout and no data. An abort input ends a request at once. A read response that is still in flight when a request ends is discarded, and no new read is issued until that response has drained. Every request finishes with a one-cycle done pulse, a 2-bit status and a data word.

A typical use is a temporal redundancy check on one core. Software or a sequencer points the block at a location and gets back either a value that held still across two reads or a clear failure code.

Top module: `stable_read_checker`

## Requirements
- R1: `startReady` is high exactly when the block is idle. A request is accepted on a cycle with `startValid` and `startReady` both high. While busy, `startReady` stays low and `startValid` has no effect, so the request's address is kept.
- R2: `memReqValid` carries the latched request address on `memReqAddr`. At most one read is outstanding: after a read handshake (`memReqValid && memReqReady`), no new read is requested until a `memRspValid` cycle has been seen.
- R3: When two successive responses of a request are equal, the block ends with status 0 (ok) and returns that word on `doneData`.
- R4: On unequal responses the block issues one further read and compares it with the previous response. A value that disagrees once therefore completes with exactly three reads in total.
- R5: With budget B, busy cycles are numbered 1, 2, … from the cycle after acceptance. A request whose matching response arrives in busy cycle n ≤ max(B,1) ends ok. Otherwise it ends after busy cycle max(B,1) with status 1 (timeout) and `doneData` = 0. A budget of 0 behaves as 1.
- R6: `abortReq` during a busy cycle produces, in the next cycle, a done pulse with status 2 (aborted) and data 0, and the block is idle again. `abortReq` while idle has no effect.
- R7: A response to a read still outstanding when a request ends is discarded. It never counts as an observation of a later request.
- R8: `doneValid` is high for one cycle per request. `doneStatus` is only ever 0, 1 or 2. `doneData` is 0 whenever the status is not 0.
- R9: After reset the block is idle: `startReady` = 1, `memReqValid` = 0, `doneValid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Request present |
| startReady | output | 1 | Block idle, request is taken this cycle |
| startAddr | input | ADDR_W (32) | Location to check |
| startBudget | input | BUDGET_W (16) | Cycle budget for this request |
| abortReq | input | 1 | End the current request |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Read request accepted by memory |
| memReqAddr | output | ADDR_W (32) | Read address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | DATA_W (32) | Read data |
| doneValid | output | 1 | One-cycle completion pulse |
| doneStatus | output | 2 | 0 ok, 1 timeout, 2 aborted |
| doneData | output | DATA_W (32) | Accepted value, 0 unless ok |

## Verification
The bound checker watches several properties on every cycle. It checks the single-outstanding-read rule and the address held steady while busy. It checks the one-cycle done pulse with its legal status codes and zeroed data, and the abort response one cycle later. It also checks that no request stays busy longer than its latched budget allows. Other behaviours can only be shown by the bench's scenarios against its cycle-level reference: which data word is accepted, the exact read count after a disagreement, the ok-versus-timeout boundary where the budget equals the completion cycle, and the discarding of a stale response after an abort.

// File: rtl/stable_chk_pkg.sv
package stable_chk_pkg;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_TIMEOUT = 2'd1,
    ST_ABORT   = 2'd2
  } doneStat_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ISSUE = 2'd1,
    PH_WAIT  = 2'd2
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic tick;
    logic reqFire;
    logic capture;
    logic finOk;
    logic finTimeout;
    logic finAbort;
  } ctrlStrb_t;

  // conditions reported by datapath to control
  typedef struct packed {
    logic outstanding;
    logic haveFirst;
    logic dataEq;
    logic expire;
  } dpFlags_t;

endpackage

// File: rtl/stable_chk_ctrl.sv
module stable_chk_ctrl
  import stable_chk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startValid,
  input  logic      abortReq,
  input  logic      memReqReady,
  input  logic      memRspValid,
  input  dpFlags_t  flags,
  output logic      startReady,
  output logic      memReqValid,
  output ctrlStrb_t strb
);

  phase_e phase;
  phase_e phaseNxt;
  logic   rspHit;

  assign startReady  = (phase == PH_IDLE);
  assign memReqValid = (phase == PH_ISSUE) && !flags.outstanding;
  assign rspHit      = (phase == PH_WAIT) && memRspValid;

  always_comb begin
    phaseNxt     = phase;
    strb         = '0;
    // a handshake with memory is a fact regardless of what else ends here
    strb.reqFire = memReqValid && memReqReady;
    if (phase == PH_IDLE) begin
      if (startValid) begin
        strb.load = 1'b1;
        phaseNxt  = PH_ISSUE;
      end
    end else if (abortReq) begin
      strb.finAbort = 1'b1;
      phaseNxt      = PH_IDLE;
    end else if (rspHit && flags.haveFirst && flags.dataEq) begin
      strb.finOk = 1'b1;
      phaseNxt   = PH_IDLE;
    end else if (flags.expire) begin
      strb.finTimeout = 1'b1;
      phaseNxt        = PH_IDLE;
    end else begin
      strb.tick = 1'b1;
      if (phase == PH_ISSUE && memReqValid && memReqReady) begin
        phaseNxt = PH_WAIT;
      end else if (rspHit) begin
        strb.capture = 1'b1;
        phaseNxt     = PH_ISSUE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNxt;
  end

endmodule

// File: rtl/stable_chk_dpath.sv
module stable_chk_dpath
  import stable_chk_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int BUDGET_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrb_t           strb,
  input  logic [ADDR_W-1:0]   startAddr,
  input  logic [BUDGET_W-1:0] startBudget,
  input  logic                memRspValid,
  input  logic [DATA_W-1:0]   memRspData,
  output dpFlags_t            flags,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic                doneValid,
  output logic [1:0]          doneStatus,
  output logic [DATA_W-1:0]   doneData
);

  localparam int CNT_W = BUDGET_W + 1;

  logic [ADDR_W-1:0]   addrQ;
  logic [BUDGET_W-1:0] budgetQ;
  logic [CNT_W-1:0]    elapsedQ;
  logic [CNT_W-1:0]    elapsedInc;
  logic [DATA_W-1:0]   firstQ;
  logic                haveFirstQ;
  logic                outstandingQ;
  doneStat_e           statNxt;

  assign elapsedInc        = elapsedQ + 1'b1;
  assign flags.expire      = (elapsedInc >= {1'b0, budgetQ});
  assign flags.dataEq      = (memRspData == firstQ);
  assign flags.haveFirst   = haveFirstQ;
  assign flags.outstanding = outstandingQ;
  assign memReqAddr        = addrQ;

  always_comb begin
    if (strb.finAbort)        statNxt = ST_ABORT;
    else if (strb.finTimeout) statNxt = ST_TIMEOUT;
    else                      statNxt = ST_OK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      budgetQ  <= '0;
      elapsedQ <= '0;
    end else if (strb.load) begin
      addrQ    <= startAddr;
      budgetQ  <= startBudget;
      elapsedQ <= '0;
    end else if (strb.tick) begin
      elapsedQ <= elapsedInc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstQ     <= '0;
      haveFirstQ <= 1'b0;
    end else if (strb.load) begin
      haveFirstQ <= 1'b0;
    end else if (strb.capture) begin
      firstQ     <= memRspData;
      haveFirstQ <= 1'b1;
    end
  end

  // single outstanding read tracker, also drains stale responses
  always_ff @(posedge clk) begin
    if (!rstN)             outstandingQ <= 1'b0;
    else if (strb.reqFire) outstandingQ <= 1'b1;
    else if (memRspValid)  outstandingQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid  <= 1'b0;
      doneStatus <= 2'd0;
      doneData   <= '0;
    end else begin
      doneValid  <= strb.finOk | strb.finTimeout | strb.finAbort;
      doneStatus <= statNxt;
      doneData   <= strb.finOk ? memRspData : '0;
    end
  end

endmodule

// File: rtl/stable_read_checker.sv
module stable_read_checker
  import stable_chk_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int BUDGET_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startValid,
  output logic                startReady,
  input  logic [ADDR_W-1:0]   startAddr,
  input  logic [BUDGET_W-1:0] startBudget,
  input  logic                abortReq,
  output logic                memReqValid,
  input  logic                memReqReady,
  output logic [ADDR_W-1:0]   memReqAddr,
  input  logic                memRspValid,
  input  logic [DATA_W-1:0]   memRspData,
  output logic                doneValid,
  output logic [1:0]          doneStatus,
  output logic [DATA_W-1:0]   doneData
);

  ctrlStrb_t strb;
  dpFlags_t  flags;

  stable_chk_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .startValid  (startValid),
    .abortReq    (abortReq),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .flags       (flags),
    .startReady  (startReady),
    .memReqValid (memReqValid),
    .strb        (strb)
  );

  stable_chk_dpath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BUDGET_W (BUDGET_W)
  ) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .startAddr   (startAddr),
    .startBudget (startBudget),
    .memRspValid (memRspValid),
    .memRspData  (memRspData),
    .flags       (flags),
    .memReqAddr  (memReqAddr),
    .doneValid   (doneValid),
    .doneStatus  (doneStatus),
    .doneData    (doneData)
  );

endmodule

// File: rtl/stable_read_checker_sva.sv
module stable_read_checker_sva #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int BUDGET_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                startValid,
  input logic                startReady,
  input logic [BUDGET_W-1:0] startBudget,
  input logic                abortReq,
  input logic                memReqValid,
  input logic                memReqReady,
  input logic [ADDR_W-1:0]   memReqAddr,
  input logic                memRspValid,
  input logic                doneValid,
  input logic [1:0]          doneStatus,
  input logic [DATA_W-1:0]   doneData
);

  localparam int CNT_W = BUDGET_W + 1;

  logic             pendRd;
  logic [CNT_W-1:0] busyCnt;
  logic [CNT_W-1:0] effBudget;

  always_ff @(posedge clk) begin
    if (!rstN)                           pendRd <= 1'b0;
    else if (memReqValid && memReqReady) pendRd <= 1'b1;
    else if (memRspValid)                pendRd <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt   <= '0;
      effBudget <= 'd1;
    end else if (startValid && startReady) begin
      busyCnt   <= '0;
      effBudget <= (startBudget == '0) ? CNT_W'(1) : {1'b0, startBudget};
    end else if (!startReady) begin
      busyCnt <= busyCnt + 1'b1;
    end
  end

  // R1
  start_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && startReady) |=> !startReady);

  // R2
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendRd |-> !memReqValid);

  // R2
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!startReady && $past(!startReady)) |-> $stable(memReqAddr));

  // R5
  budget_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    !startReady |-> (busyCnt < effBudget));

  // R6
  abort_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    (abortReq && !startReady) |=> (doneValid && doneStatus == 2'd2));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R8
  status_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (doneStatus != 2'd3));

  // R8
  fail_zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneStatus != 2'd0) |-> (doneData == '0));

endmodule

bind stable_read_checker stable_read_checker_sva #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .BUDGET_W (BUDGET_W)
) sva_i (
  .clk         (clk),
  .rstN        (rstN),
  .startValid  (startValid),
  .startReady  (startReady),
  .startBudget (startBudget),
  .abortReq    (abortReq),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqAddr  (memReqAddr),
  .memRspValid (memRspValid),
  .doneValid   (doneValid),
  .doneStatus  (doneStatus),
  .doneData    (doneData)
);

// File: tb/stable_read_checker_tb.sv
module stable_read_checker_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic        startReady;
  logic [31:0] startAddr = '0;
  logic [15:0] startBudget = '0;
  logic        abortReq = 1'b0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        doneValid;
  logic [1:0]  doneStatus;
  logic [31:0] doneData;

  always #10 clk = ~clk;

  stable_read_checker dut_i (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startReady(startReady),
    .startAddr(startAddr), .startBudget(startBudget), .abortReq(abortReq),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .doneValid(doneValid),
    .doneStatus(doneStatus), .doneData(doneData)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model state
  bit          mBusy = 0, mInWait = 0, mHave = 0, mOut = 0;
  logic [31:0] mFirst = '0, mAddr = '0;
  int          mElapsed = 0, mBudget = 0;
  bit          expDoneV = 0;
  int          expDoneS = 0;
  logic [31:0] expDoneD = '0;

  // memory environment
  logic [31:0] memArr [16];
  int          lat = 1, stallCfg = 0, stallCnt = 0, rspTimer = 0, reads = 0;
  logic [31:0] rspData = '0;
  logic [31:0] flipQ [$];
  bit          flipAll = 0;

  // what the last step observed
  bit          sawDone = 0;
  int          sawStatus = 0;
  logic [31:0] sawData = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic step();
    bit expReq, hs, rsp, nDone;
    int nStat;
    logic [31:0] nData, mask;
    memRspValid = 1'b0;
    if (rspTimer > 0) begin
      rspTimer--;
      if (rspTimer == 0) begin
        memRspValid = 1'b1;
        memRspData  = rspData;
      end
    end
    memReqReady = (stallCnt == 0);
    #1;
    expReq = mBusy && !mInWait && !mOut;
    chk(startReady == !mBusy, "R1 startReady", startReady, !mBusy);
    chk(memReqValid == expReq, "R2 memReqValid", memReqValid, expReq);
    if (expReq) chk(memReqAddr == mAddr, "R2 memReqAddr", memReqAddr, mAddr);
    chk(doneValid == expDoneV, "R8 doneValid", doneValid, expDoneV);
    if (expDoneV) begin
      chk(doneStatus == 2'(expDoneS), "R8 doneStatus", doneStatus, expDoneS);
      chk(doneData == expDoneD, "R3 doneData", doneData, expDoneD);
    end
    sawDone = doneValid; sawStatus = doneStatus; sawData = doneData;
    // advance reference by one edge
    hs = expReq && memReqReady;
    rsp = memRspValid;
    nDone = 0; nStat = 0; nData = '0;
    if (!mBusy) begin
      if (startValid) begin
        mBusy = 1; mAddr = startAddr; mBudget = startBudget;
        mElapsed = 0; mHave = 0; mInWait = 0;
      end
    end else if (abortReq) begin
      nDone = 1; nStat = 2; mBusy = 0; mInWait = 0;
    end else if (mInWait && rsp && mHave && memRspData == mFirst) begin
      nDone = 1; nStat = 0; nData = memRspData; mBusy = 0; mInWait = 0;
    end else if (mElapsed + 1 >= mBudget) begin
      nDone = 1; nStat = 1; mBusy = 0; mInWait = 0;
    end else begin
      mElapsed++;
      if (!mInWait && hs) mInWait = 1;
      else if (mInWait && rsp) begin
        mFirst = memRspData; mHave = 1; mInWait = 0;
      end
    end
    if (hs) mOut = 1; else if (rsp) mOut = 0;
    if (hs) begin
      mask = '0;
      if (flipAll) mask = 32'(reads);
      else if (flipQ.size() > 0) mask = flipQ.pop_front();
      rspTimer = lat;
      rspData  = memArr[mAddr[3:0]] ^ mask;
      reads++;
      stallCnt = stallCfg;
    end else if (expReq && stallCnt > 0) stallCnt--;
    expDoneV = nDone; expDoneS = nStat; expDoneD = nData;
    @(negedge clk);
    cycles++;
    if (cycles > 150000) begin
      chk(0, "watchdog", cycles, 0);
      finishRun();
    end
  endtask

  task automatic runReq(input logic [31:0] a, input int b, output int st,
                        output logic [31:0] d, output int n);
    startValid = 1; startAddr = a; startBudget = 16'(b);
    step();
    startValid = 0;
    n = 1;
    while (!sawDone && n < 2000) begin
      step();
      n++;
    end
    st = sawStatus; d = sawData;
  endtask

  initial begin
    #4_000_000;
    chk(0, "watchdog", cycles, 0);
    finishRun();
  end

  initial begin
    int st, n, r0;
    logic [31:0] d;
    for (int i = 0; i < 16; i++) memArr[i] = 32'hA500_0000 + 32'(i) * 32'h0101_0101;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R9 reset state
    chk(startReady == 1'b1, "R9 startReady", startReady, 1);
    chk(memReqValid == 1'b0, "R9 memReqValid", memReqValid, 0);
    chk(doneValid == 1'b0, "R9 doneValid", doneValid, 0);
    @(negedge clk);

    // R3 clean read, latency 1
    r0 = reads;
    runReq(32'd3, 50, st, d, n);
    chk(st == 0, "R3 status", st, 0);
    chk(d == memArr[3], "R3 data", d, memArr[3]);
    chk(reads - r0 == 2, "R3 reads", reads - r0, 2);
    chk(n == 6, "R3 latency", n, 6);
    step();

    // R4 one disagreement costs one extra read
    r0 = reads;
    flipQ.push_back(32'h0000_0100);
    runReq(32'd5, 50, st, d, n);
    chk(st == 0 && d == memArr[5], "R4 data after retry", d, memArr[5]);
    chk(reads - r0 == 3, "R4 read count", reads - r0, 3);
    step();

    // R4 second read corrupted twice in a row
    r0 = reads;
    flipQ.push_back(32'h0); flipQ.push_back(32'h8000_0000); flipQ.push_back(32'h1);
    runReq(32'd6, 50, st, d, n);
    chk(st == 0 && d == memArr[6], "R4 data after two retries", d, memArr[6]);
    chk(reads - r0 == 5, "R4 read count 2", reads - r0, 5);
    step();

    // R5 never stable: timeout after exactly the budget
    flipAll = 1;
    runReq(32'd7, 20, st, d, n);
    chk(st == 1, "R5 timeout status", st, 1);
    chk(d == 0, "R5 timeout data", d, 0);
    chk(n == 22, "R5 timeout cycle", n, 22);
    flipAll = 0;
    repeat (3) step();

    // R5 boundary: match in busy cycle 4
    runReq(32'd8, 4, st, d, n);
    chk(st == 0 && d == memArr[8], "R5 budget equal ok", st, 0);
    step();
    runReq(32'd8, 3, st, d, n);
    chk(st == 1 && n == 5, "R5 budget short timeout", n, 5);
    repeat (2) step();
    runReq(32'd9, 0, st, d, n);
    chk(st == 1 && n == 3, "R5 budget zero", n, 3);
    repeat (2) step();

    // R2 stalled memory, longer latency
    stallCfg = 3; stallCnt = 3; lat = 4;
    runReq(32'd10, 100, st, d, n);
    chk(st == 0 && d == memArr[10], "R2 stalled ok", d, memArr[10]);
    stallCfg = 0; stallCnt = 0;
    repeat (6) step();

    // R6 abort while a read is in flight, R7 stale response dropped
    lat = 6;
    startValid = 1; startAddr = 32'd11; startBudget = 16'd200;
    step();
    startValid = 0;
    repeat (2) step();
    abortReq = 1;
    step();
    abortReq = 0;
    step();
    chk(sawDone && sawStatus == 2, "R6 abort status", sawStatus, 2);
    chk(sawData == 0, "R6 abort data", sawData, 0);
    lat = 1;
    r0 = reads;
    runReq(32'd12, 100, st, d, n);
    chk(st == 0 && d == memArr[12], "R7 stale discarded", d, memArr[12]);
    chk(reads - r0 == 2, "R7 reads after drain", reads - r0, 2);
    step();

    // R6 abort while idle has no effect
    abortReq = 1;
    step(); step();
    abortReq = 0;
    chk(!sawDone && startReady, "R6 idle abort ignored", sawDone, 0);
    step();

    // R1 start held during busy with another address is ignored
    startValid = 1; startAddr = 32'd13; startBudget = 16'd50;
    step();
    startAddr = 32'd14;
    n = 1;
    while (!sawDone && n < 100) begin step(); n++; end
    startValid = 0;
    chk(sawStatus == 0 && sawData == memArr[13], "R1 address kept", sawData, memArr[13]);
    repeat (10) step();

    finishRun();
  end

endmodule